// File: doc/BRIEF.md
# Configuration Request Descriptor Engine

This block sits between a 32-bit register bus and a configuration-space access port. Software fills three descriptor words, an optional spare descriptor word and a write-data word, then writes the trigger bit. The engine takes a snapshot of the descriptor and decodes the request kind, the target bus, the device/function and the register offset. It then issues a single request on a valid/ready port. When the request is a write, the enabled bytes are packed into a contiguous run first.

The response comes back on a one-cycle response-valid strobe. A device that is absent can say so with a flag, or it can stay silent until a timeout runs out. Read data goes into a result register. An absent device fills that register with all ones. Completion is signalled through a done interrupt flag and through two transmit status bits that software clears on its own. The root bus number is replaced by bus zero before the request leaves the block.

Top module: `cfgd_engine`

## Requirements
- R1: After reset, every readable register (0x0C, 0x24, 0xC8, 0xCC) reads zero, `done_irq` is low and no request is presented.
- R2: The kind is taken from descriptor word 0 (0x10) bits [31:24]. 0x04 and 0x05 select a read, and 0x44 and 0x45 select a write. Any other code issues no request and leaves the result register unchanged, but the transaction still completes.
- R3: The request takes its bus from descriptor word 2 (0x18) bits [31:24], its device/function from bits [23:16] and its dword offset from bits [11:2]. A bus equal to ROOT_BUS (0x80) is sent as bus 0. Any other bus, 0x81 included, is sent unchanged.
- R4: A read is issued with length 4 at the dword offset. The response data is stored in the result register at 0xCC.
- R5: If the response carries the no-device flag, or if no response arrives within TIMEOUT cycles after the request is accepted, the result register is loaded with 0xFFFFFFFF. This applies to both reads and writes.
- R6: Write byte enables come from descriptor word 1 (0x14) bits [3:0]. The enabled bytes of the write-data word (0x20) are packed toward byte 0 in ascending lane order. The offset grows by the index of the lowest enabled lane, and the length equals the number of enabled lanes. Enable 0xF gives a plain 4-byte write.
- R7: A write whose byte enables are all zero issues no request and still completes.
- R8: On completion the block sets bit 4 of the interrupt status register (0xC8), sets bits 25 (complete) and 31 (idle) of the transmit status register (0x24), and raises `done_irq`.
- R9: Writing 1 to bit 0 of 0x08 clears the idle bit. Writing 1 to bit 4 of 0x00 sets the register at 0x0C to all ones. Other bits of 0x00 have no effect.
- R10: Writing 1 to bit 4 of 0xC8 clears the done flag and status bit 25. The idle bit is left unchanged.
- R11: A trigger (write of 1 to bit 0 of 0x24) that arrives while a transaction is in flight is ignored. It causes no second request and no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address (write and read) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_bus | output | 8 | Target bus after root remap |
| req_devfn | output | 8 | Target device/function |
| req_offset | output | 12 | Byte offset of the first byte accessed |
| req_len | output | 3 | Number of bytes (1 to 4) |
| req_wdata | output | 32 | Packed write data |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_nodev | input | 1 | Response reports that no device is present |
| rsp_data | input | 32 | Response read data |
| done_irq | output | 1 | Done interrupt flag |

## Verification
Reads are issued to the root bus, to an ordinary bus and to the neighbouring bus 0x81. This shows that only the exact root number is remapped. Write enables 0xF, 0x5, 0xC, 0x8, 0x2 and 0x0 separate full writes, sparse packing, the offset shift by the lowest lane and the empty request. Unknown kind codes show that nothing is issued. Absent devices are exercised in both forms, the explicit flag and silence until timeout, and each must load all ones over a previously distinct result. A second trigger during a silent transaction and a downstream port that stalls on ready check that the request held in flight is neither replaced nor repeated.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

  localparam int DW = 32;

  localparam logic [7:0] A_CTRL    = 8'h00;
  localparam logic [7:0] A_TXCLR   = 8'h08;
  localparam logic [7:0] A_RXFILL  = 8'h0C;
  localparam logic [7:0] A_DESC0   = 8'h10;
  localparam logic [7:0] A_WDATA   = 8'h20;
  localparam logic [7:0] A_TXSTAT  = 8'h24;
  localparam logic [7:0] A_INTSTAT = 8'hC8;
  localparam logic [7:0] A_RESULT  = 8'hCC;

  localparam logic [7:0] K_RD0 = 8'h04;
  localparam logic [7:0] K_RD1 = 8'h05;
  localparam logic [7:0] K_WR0 = 8'h44;
  localparam logic [7:0] K_WR1 = 8'h45;

  typedef struct packed {
    logic          issue;
    logic          write;
    logic [7:0]    bus;
    logic [7:0]    devfn;
    logic [11:0]   offset;
    logic [2:0]    len;
    logic [DW-1:0] data;
  } cfg_req_t;

  function automatic logic [2:0] be_count(input logic [3:0] be);
    logic [2:0] n;
    n = 3'd0;
    for (int i = 0; i < 4; i++) n = n + {2'b00, be[i]};
    return n;
  endfunction

  function automatic logic [1:0] be_first(input logic [3:0] be);
    logic [1:0] f;
    f = 2'd0;
    for (int i = 3; i >= 0; i--) if (be[i]) f = 2'(i);
    return f;
  endfunction

  function automatic logic [DW-1:0] be_pack(input logic [3:0] be,
                                            input logic [DW-1:0] d);
    logic [DW-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        r[k*8 +: 8] = d[i*8 +: 8];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgd_decode.sv
module cfgd_decode
  import cfgd_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input  logic [7:0]    kind,
  input  logic [3:0]    be,
  input  logic [7:0]    bus,
  input  logic [7:0]    devfn,
  input  logic [9:0]    dw_idx,
  input  logic [DW-1:0] wd,
  output cfg_req_t      req
);

  logic        is_rd;
  logic        is_wr;
  logic [11:0] base;

  assign is_rd = (kind == K_RD0) || (kind == K_RD1);
  assign is_wr = (kind == K_WR0) || (kind == K_WR1);
  assign base  = {dw_idx, 2'b00};

  always_comb begin
    req        = '0;
    req.bus    = (bus == ROOT_BUS) ? 8'h00 : bus;
    req.devfn  = devfn;
    req.offset = base;
    if (is_rd) begin
      req.issue = 1'b1;
      req.write = 1'b0;
      req.len   = 3'd4;
    end else if (is_wr) begin
      req.issue  = (be != 4'h0);
      req.write  = 1'b1;
      req.len    = be_count(be);
      req.offset = base + {10'b0, be_first(be)};
      req.data   = be_pack(be, wd);
    end
  end

endmodule

// File: rtl/cfgd_seq.sv
module cfgd_seq
  import cfgd_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  cfg_req_t      req_in,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          rsp_nodev,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          fin,
  output logic          load_result,
  output logic [DW-1:0] result_val,
  output logic          req_valid,
  output cfg_req_t      req_q
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e           st;
  logic [TW-1:0] tmr;
  logic          nodev_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      nodev_q <= 1'b0;
      data_q  <= '0;
      req_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (trig) begin
          req_q   <= req_in;
          nodev_q <= 1'b0;
          data_q  <= '0;
          st      <= req_in.issue ? S_ISSUE : S_DONE;
        end
        S_ISSUE: if (req_ready) begin
          tmr <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            nodev_q <= rsp_nodev;
            data_q  <= rsp_data;
            st      <= S_DONE;
          end else if (tmr == TLAST) begin
            nodev_q <= 1'b1;
            st      <= S_DONE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign fin         = (st == S_DONE);
  assign req_valid   = (st == S_ISSUE);
  assign load_result = fin && req_q.issue && (nodev_q || !req_q.write);
  assign result_val  = nodev_q ? '1 : data_q;

endmodule

// File: rtl/cfgd_engine.sv
module cfgd_engine
  import cfgd_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS = 8'h80,
  parameter int         TIMEOUT  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [7:0]  req_bus,
  output logic [7:0]  req_devfn,
  output logic [11:0] req_offset,
  output logic [2:0]  req_len,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_nodev,
  input  logic [31:0] rsp_data,
  output logic        done_irq
);

  localparam int NDESC = 4;

  logic [DW-1:0] desc_q [NDESC];
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rxfill_q;
  logic [DW-1:0] result_q;
  logic          idle_q;
  logic          comp_q;
  logic          done_q;

  logic          trig_hit;
  logic          clr_done_hit;
  logic          clr_idle_hit;
  logic          fill_hit;
  logic          busy;
  logic          fin;
  logic          load_result;
  logic [DW-1:0] result_val;
  cfg_req_t      dec_req;
  cfg_req_t      cur_req;

  assign trig_hit     = bus_we && (bus_addr == A_TXSTAT)  && bus_wdata[0];
  assign clr_done_hit = bus_we && (bus_addr == A_INTSTAT) && bus_wdata[4];
  assign clr_idle_hit = bus_we && (bus_addr == A_TXCLR)   && bus_wdata[0];
  assign fill_hit     = bus_we && (bus_addr == A_CTRL)    && bus_wdata[4];

  for (genvar g = 0; g < NDESC; g++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) desc_q[g] <= '0;
      else if (bus_we && (bus_addr == A_DESC0 + 8'(4 * g))) desc_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q  <= '0;
      rxfill_q <= '0;
      result_q <= '0;
      idle_q   <= 1'b0;
      comp_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == A_WDATA)) wdata_q <= bus_wdata;
      if (fill_hit) rxfill_q <= '1;
      if (load_result) result_q <= result_val;
      if (fin) begin
        done_q <= 1'b1;
        comp_q <= 1'b1;
      end else if (clr_done_hit) begin
        done_q <= 1'b0;
        comp_q <= 1'b0;
      end
      if (fin) idle_q <= 1'b1;
      else if (clr_idle_hit) idle_q <= 1'b0;
    end
  end

  cfgd_decode #(.ROOT_BUS(ROOT_BUS)) u_decode (
    .kind   (desc_q[0][31:24]),
    .be     (desc_q[1][3:0]),
    .bus    (desc_q[2][31:24]),
    .devfn  (desc_q[2][23:16]),
    .dw_idx (desc_q[2][11:2]),
    .wd     (wdata_q),
    .req    (dec_req)
  );

  cfgd_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig_hit),
    .req_in      (dec_req),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_nodev   (rsp_nodev),
    .rsp_data    (rsp_data),
    .busy        (busy),
    .fin         (fin),
    .load_result (load_result),
    .result_val  (result_val),
    .req_valid   (req_valid),
    .req_q       (cur_req)
  );

  assign req_write  = cur_req.write;
  assign req_bus    = cur_req.bus;
  assign req_devfn  = cur_req.devfn;
  assign req_offset = cur_req.offset;
  assign req_len    = cur_req.len;
  assign req_wdata  = cur_req.data;
  assign done_irq   = done_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RXFILL:      bus_rdata = rxfill_q;
      A_DESC0:       bus_rdata = desc_q[0];
      A_DESC0 + 8'd4:  bus_rdata = desc_q[1];
      A_DESC0 + 8'd8:  bus_rdata = desc_q[2];
      A_DESC0 + 8'd12: bus_rdata = desc_q[3];
      A_WDATA:       bus_rdata = wdata_q;
      A_TXSTAT:      bus_rdata = {idle_q, 5'b0, comp_q, 25'b0};
      A_INTSTAT:     bus_rdata = {27'b0, done_q, 4'b0};
      A_RESULT:      bus_rdata = result_q;
      default:       bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgd_engine_chk.sv
module cfgd_engine_chk #(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        fin,
  input logic        trig_hit,
  input logic        clr_done_hit,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_bus,
  input logic [11:0] req_offset,
  input logic [2:0]  req_len,
  input logic [31:0] req_wdata,
  input logic        done_irq
);

  a_r3_root_remapped: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bus != ROOT_BUS));

  a_r6_len_in_dword: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |->
      (req_len != 3'd0) && (({2'b00, req_offset[1:0]} + {1'b0, req_len}) <= 4'd4));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_offset) && $stable(req_wdata) && $stable(req_bus)));

  a_r8_done_raised: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_irq);

  a_r10_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done_hit && !fin) |=> !done_irq);

  a_r11_busy_trigger_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_hit && !fin) |=> (busy && $stable(req_offset) && $stable(req_bus)));

  a_r2_valid_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

endmodule

bind cfgd_engine cfgd_engine_chk #(.ROOT_BUS(ROOT_BUS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .fin          (fin),
  .trig_hit     (trig_hit),
  .clr_done_hit (clr_done_hit),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_bus      (req_bus),
  .req_offset   (req_offset),
  .req_len      (req_len),
  .req_wdata    (req_wdata),
  .done_irq     (done_irq)
);

// File: tb/cfgd_engine_bench.sv
`timescale 1ns/1ps
module cfgd_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_bus, req_devfn;
  logic [11:0] req_offset;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0, rsp_nodev = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        done_irq;

  int vectors = 0;
  int misses  = 0;

  always #2 clk = ~clk;

  cfgd_engine u_cfgd_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_offset(req_offset), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_nodev(rsp_nodev),
    .rsp_data(rsp_data), .done_irq(done_irq)
  );

  // ---------------- device stand-in ----------------
  // kind 0: present, 1: answers with no-device flag, 2: silent
  function automatic int dev_kind(input logic [7:0] b, input logic [7:0] df);
    if ((b == 8'h00 || b == 8'h01) && df[7:3] == 5'd0) return 0;
    if (b == 8'h22) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] dev_data(input logic [7:0] b, input logic [7:0] df,
                                           input logic [11:0] o);
    return {df, b, 4'h5, o};
  endfunction

  logic        stall_mode = 1'b0;
  logic [1:0]  rdy_cnt = 2'd0;
  assign req_ready = !stall_mode || (rdy_cnt == 2'd3);

  int          pend_kind = 0;
  logic        pend = 1'b0;
  int          pend_dly = 0;
  logic [31:0] pend_data = '0;
  logic [63:0] seen_q[$];

  always @(posedge clk) begin
    rdy_cnt   <= rdy_cnt + 2'd1;
    rsp_valid <= 1'b0;
    rsp_nodev <= 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        pend <= 1'b0;
        if (pend_kind != 2) begin
          rsp_valid <= 1'b1;
          rsp_nodev <= (pend_kind == 1);
          rsp_data  <= (pend_kind == 0) ? pend_data : 32'hDEAD0000;
        end
      end else pend_dly <= pend_dly - 1;
    end
    if (req_valid && req_ready) begin
      seen_q.push_back({req_write, req_len, req_bus, req_devfn, req_offset, req_wdata});
      pend      <= 1'b1;
      pend_dly  <= 2;
      pend_kind <= dev_kind(req_bus, req_devfn);
      pend_data <= dev_data(req_bus, req_devfn, req_offset);
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done_irq && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(done_irq == 1'b1, tag, {63'b0, done_irq}, 64'd1);
  endtask

  // reference model state
  logic [31:0] m_result = '0;

  task automatic txn(input logic [31:0] d0, input logic [31:0] d1,
                     input logic [31:0] d2, input logic [31:0] wd, input string tag);
    logic [7:0]  k, b;
    logic [3:0]  be;
    bit          rdk, wrk, issue;
    logic [63:0] exp_pkt;
    logic [31:0] pk, v;
    logic [11:0] off;
    int          cnt, low;
    k   = d0[31:24];
    be  = d1[3:0];
    rdk = (k == 8'h04 || k == 8'h05);
    wrk = (k == 8'h44 || k == 8'h45);
    b   = (d2[31:24] == 8'h80) ? 8'h00 : d2[31:24];
    issue = rdk || (wrk && be != 4'h0);
    pk = '0; cnt = 0; low = 4;
    for (int i = 3; i >= 0; i--) if (be[i]) begin
      pk = (pk << 8) | {24'b0, wd[i*8 +: 8]};
      cnt++;
      low = i;
    end
    off = {d2[11:2], 2'b00};
    if (rdk) exp_pkt = {1'b0, 3'd4, b, d2[23:16], off, 32'h0};
    else     exp_pkt = {1'b1, 3'(cnt), b, d2[23:16], off + 12'(low), pk};
    if (issue) begin
      if (dev_kind(b, d2[23:16]) != 0) m_result = 32'hFFFFFFFF;
      else if (rdk) m_result = dev_data(b, d2[23:16], off);
    end
    seen_q.delete();
    wr(8'h10, d0); wr(8'h14, d1); wr(8'h18, d2); wr(8'h20, wd);
    wr(8'h24, 32'h1);
    wait_done({tag, " R8 done"});
    check(seen_q.size() == (issue ? 1 : 0), {tag, " request count"},
          64'(seen_q.size()), issue ? 64'd1 : 64'd0);
    if (issue && seen_q.size() == 1)
      check(seen_q[0] == exp_pkt, {tag, " request"}, seen_q[0], exp_pkt);
    rd(8'hCC, v);
    check(v == m_result, {tag, " result"}, {32'b0, v}, {32'b0, m_result});
    rd(8'h24, v);
    check(v[31] && v[25], {tag, " R8 txstat"}, {32'b0, v}, 64'h82000000);
    rd(8'hC8, v);
    check(v == 32'h10, {tag, " R8 intstat"}, {32'b0, v}, 64'h10);
    wr(8'hC8, 32'h10);
    rd(8'hC8, v);
    check(v == 32'h0 && !done_irq, {tag, " R10 int cleared"}, {32'b0, v}, 64'h0);
    rd(8'h24, v);
    check(v == 32'h80000000, {tag, " R10 idle kept"}, {32'b0, v}, 64'h80000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h0C, v); check(v == 0, "R1 rxfill", {32'b0, v}, 0);
    rd(8'h24, v); check(v == 0, "R1 txstat", {32'b0, v}, 0);
    rd(8'hC8, v); check(v == 0, "R1 intstat", {32'b0, v}, 0);
    rd(8'hCC, v); check(v == 0, "R1 result", {32'b0, v}, 0);
    check(!done_irq && !req_valid, "R1 outputs idle", {62'b0, done_irq, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'hCC, v); check(v == 0, "R1 result after release", {32'b0, v}, 0);

    // R4 / R3 reads: root remap and ordinary bus, stalled ready on second
    txn(32'h04000000, 32'h0, 32'h80020010, 32'h0, "R4 R3 root read");
    stall_mode = 1'b1;
    txn(32'h05000000, 32'h0, 32'h01010FFC, 32'h0, "R4 bus1 read stalled");
    stall_mode = 1'b0;

    // R6 write packing
    txn(32'h44000000, 32'hF, 32'h00000040, 32'h11223344, "R6 full write");
    txn(32'h45000000, 32'h5, 32'h00000080, 32'hAABBCCDD, "R6 lanes 0 and 2");
    txn(32'h44000000, 32'hC, 32'h00000080, 32'hAABBCCDD, "R6 upper half");
    txn(32'h44000000, 32'h8, 32'h00000084, 32'hAABBCCDD, "R6 lane 3");
    txn(32'h44000000, 32'h2, 32'h00010084, 32'hAABBCCDD, "R6 lane 1");

    // R7 empty write, R2 unknown kinds
    txn(32'h44000000, 32'h0, 32'h00000040, 32'h12345678, "R7 empty enables");
    txn(32'h20000000, 32'hF, 32'h00000040, 32'h12345678, "R2 kind 0x20");
    txn(32'h06000000, 32'hF, 32'h00000044, 32'h12345678, "R2 kind 0x06");

    // R5 absent device: explicit flag, then timeout after a fresh good read
    txn(32'h04000000, 32'h0, 32'h22000008, 32'h0, "R5 nodev flag");
    txn(32'h04000000, 32'h0, 32'h00030020, 32'h0, "R4 refresh result");
    txn(32'h04000000, 32'h0, 32'h33000020, 32'h0, "R5 timeout");
    txn(32'h04000000, 32'h0, 32'h00030024, 32'h0, "R4 refresh again");
    txn(32'h44000000, 32'h3, 32'h22000024, 32'h0, "R5 write to absent");

    // R3 neighbouring bus not remapped
    txn(32'h05000000, 32'h0, 32'h81050030, 32'h0, "R3 bus 0x81 kept");

    // R11 trigger while busy
    seen_q.delete();
    wr(8'h10, 32'h04000000); wr(8'h18, 32'h33070010); wr(8'h24, 32'h1);
    repeat (3) @(negedge clk);
    wr(8'h18, 32'h00000014); wr(8'h24, 32'h1);
    wait_done("R11 first completion");
    check(seen_q.size() == 1, "R11 one request", 64'(seen_q.size()), 1);
    if (seen_q.size() >= 1)
      check(seen_q[0][59:52] == 8'h33, "R11 first request kept",
            {56'b0, seen_q[0][59:52]}, 64'h33);
    wr(8'hC8, 32'h10);
    seen_q.delete();
    repeat (40) @(negedge clk);
    check(!done_irq && seen_q.size() == 0, "R11 no second completion",
          {63'b0, done_irq}, 0);

    // R9 idle clear and fill control
    wr(8'h08, 32'h1);
    rd(8'h24, v); check(v == 0, "R9 idle cleared", {32'b0, v}, 0);
    wr(8'h00, 32'h0000_000F);
    rd(8'h0C, v); check(v == 0, "R9 other ctrl bits ignored", {32'b0, v}, 0);
    wr(8'h00, 32'h10);
    rd(8'h0C, v); check(v == 32'hFFFFFFFF, "R9 fill all ones", {32'b0, v}, 64'hFFFFFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule